// File: doc/BRIEF.md
# Protection Region Bound Decoder

This block keeps the per-entry configuration bytes and address registers of a physical memory protection unit and turns each entry into an explicit inclusive byte range. Software-side logic writes one entry at a time through a single write port. The port gives an entry index, a flag that selects the configuration byte or the address register, and the data. The block then recomputes the first and last byte address that entry covers. A permission checker reads these bounds for all entries in parallel. It never has to decode match modes on its own critical path.

Each address register holds a byte address divided by four. Decoded bounds are therefore two bits wider than the register, so every mode can reach the top of the address space without wrapping. A write lands in the register file on one clock edge. The affected bounds and the count of enabled entries are refreshed on the next edge. A busy flag marks the cycle in between.

Top module: `pmp_range_decoder`

## Requirements
- R1: After synchronous reset, every configuration byte and address register is zero, every entry reports lower bound 0 and upper bound all ones, the enabled-entry count is 0 and busy is low.
- R2: The match mode is configuration bits [4:3], with 00 off, 01 top-of-range, 10 four-byte, 11 power-of-two. An entry in the off mode reports lower bound 0 and upper bound all ones.
- R3: In top-of-range mode, the lower bound is the preceding entry's address register times four, and entry 0 uses 0 for it. The upper bound is this entry's address register times four minus one, modulo 2^(XLEN+2), so a zero register gives all ones.
- R4: In four-byte mode, the lower bound is the address register times four and the upper bound is that value plus 3.
- R5: In power-of-two mode with t trailing ones in the address register (t < XLEN), the lower bound is the register with its low t bits cleared, times four. The upper bound is the lower bound plus 2^(t+3) minus 1.
- R6: In power-of-two mode, an address register of all ones gives lower bound 0 and upper bound all ones.
- R7: The enabled-entry count equals the number of entries whose mode is not off, and it is refreshed after every write.
- R8: A write sampled at clock edge k raises busy for exactly the following cycle. New bounds and count appear at edge k+1. Bounds never change at an edge where busy was low.
- R9: A write to the address register of entry i also re-decodes entry i+1, so a top-of-range successor picks up its new lower bound.
- R10: A write changes only the addressed entry and, per R9, its successor. The bounds of all other entries are left unchanged. wr_sel=0 writes wr_data[7:0] to the configuration byte, and wr_sel=1 writes the whole of wr_data to the address register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one entry per cycle |
| wr_idx | input | max(1,clog2(NUM_ENTRIES)) | Entry index of the write |
| wr_sel | input | 1 | 0 = configuration byte, 1 = address register |
| wr_data | input | XLEN | Write data |
| busy_o | output | 1 | High during the cycle when bounds are being refreshed |
| active_cnt_o | output | clog2(NUM_ENTRIES+1) | Number of entries not in off mode |
| rng_lo_o | output | NUM_ENTRIES*(XLEN+2) | Lower bounds, entry i at bits [i*(XLEN+2) +: XLEN+2] |
| rng_hi_o | output | NUM_ENTRIES*(XLEN+2) | Upper bounds, same packing |

## Verification
The bench builds the block with NUM_ENTRIES=4 and XLEN=16, which gives 18-bit bounds. With these values, power-of-two regions with t=0, t=10, t=14, t=15 and the all-ones register can all be checked against short hand-computed constants. The last entry, which has no successor, is also exercised. Top-of-range chaining, the zero-register wrap and a successor refresh caused by an address write are all reachable within four entries. The busy cycle is observed in between, before the new bounds appear.

// File: rtl/pmp_dec_pkg.sv
package pmp_dec_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_TOR   = 2'b01,
        MODE_NA4   = 2'b10,
        MODE_NAPOT = 2'b11
    } amode_e;

    localparam int MODE_LSB = 3;

    function automatic amode_e mode_of(input logic [7:0] cfg);
        return amode_e'(cfg[MODE_LSB+1:MODE_LSB]);
    endfunction

endpackage

// File: rtl/pmp_trail_ones.sv
module pmp_trail_ones #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [CW-1:0] cnt
);
    // Priority encoder: position of the lowest zero bit, W when none.
    always_comb begin
        cnt = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!val[i]) cnt = CW'(i);
        end
    end
endmodule

// File: rtl/pmp_entry_decode.sv
module pmp_entry_decode
    import pmp_dec_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PAW  = XLEN + 2,
    parameter int CW   = $clog2(XLEN + 1)
) (
    input  amode_e            mode,
    input  logic [XLEN-1:0]   addr,
    input  logic [XLEN-1:0]   prev_addr,
    output logic [PAW-1:0]    lo,
    output logic [PAW-1:0]    hi
);
    logic [CW-1:0]  ones;
    logic [PAW-1:0] a_sh;
    logic [PAW-1:0] p_sh;
    logic [PAW-1:0] nmask;
    int unsigned    sh;

    pmp_trail_ones #(.W(XLEN), .CW(CW)) u_ones (
        .val (addr),
        .cnt (ones)
    );

    assign a_sh = {addr, 2'b00};
    assign p_sh = {prev_addr, 2'b00};

    always_comb begin
        sh    = int'(ones) + 3;
        nmask = ~({PAW{1'b1}} << sh);
        lo    = '0;
        hi    = '1;
        unique case (mode)
            MODE_OFF: begin
                lo = '0;
                hi = '1;
            end
            MODE_TOR: begin
                lo = p_sh;
                hi = a_sh - PAW'(1);
            end
            MODE_NA4: begin
                lo = a_sh;
                hi = a_sh | PAW'(3);
            end
            MODE_NAPOT: begin
                if (ones == CW'(XLEN)) begin
                    lo = '0;
                    hi = '1;
                end else begin
                    lo = a_sh & ~nmask;
                    hi = (a_sh & ~nmask) | nmask;
                end
            end
            default: begin
                lo = '0;
                hi = '1;
            end
        endcase
    end
endmodule

// File: rtl/pmp_rule_count.sv
module pmp_rule_count
    import pmp_dec_pkg::*;
#(
    parameter int N    = 8,
    parameter int CNTW = $clog2(N + 1)
) (
    input  logic [N*8-1:0]  cfg_flat,
    output logic [CNTW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            if (mode_of(cfg_flat[i*8 +: 8]) != MODE_OFF) cnt = cnt + CNTW'(1);
        end
    end
endmodule

// File: rtl/pmp_range_decoder.sv
module pmp_range_decoder
    import pmp_dec_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int XLEN        = 32,
    localparam int IW   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int PAW  = XLEN + 2,
    localparam int CW   = $clog2(XLEN + 1),
    localparam int CNTW = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IW-1:0]              wr_idx,
    input  logic                       wr_sel,
    input  logic [XLEN-1:0]            wr_data,
    output logic                       busy_o,
    output logic [CNTW-1:0]            active_cnt_o,
    output logic [NUM_ENTRIES*PAW-1:0] rng_lo_o,
    output logic [NUM_ENTRIES*PAW-1:0] rng_hi_o
);
    localparam int N = NUM_ENTRIES;

    logic [7:0]       cfg_q  [N];
    logic [XLEN-1:0]  addr_q [N];
    logic [PAW-1:0]   lo_q   [N];
    logic [PAW-1:0]   hi_q   [N];
    logic [PAW-1:0]   dec_lo [N];
    logic [PAW-1:0]   dec_hi [N];
    amode_e           mode_w [N];
    logic [N-1:0]     pend_q;
    logic [N-1:0]     pend_d;
    logic             busy_q;
    logic [CNTW-1:0]  cnt_q;
    logic [CNTW-1:0]  cnt_d;
    logic [N*8-1:0]   cfg_flat;
    logic             idx_ok;

    assign idx_ok = (int'(wr_idx) < N);

    // Entries to refresh next cycle: the written one, plus its successor on
    // an address write (a top-of-range successor takes its base from here).
    always_comb begin
        for (int i = 0; i < N; i++) begin
            pend_d[i] = wr_en && idx_ok &&
                        ((int'(wr_idx) == i) ||
                         (wr_sel && (i > 0) && (int'(wr_idx) == i - 1)));
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [XLEN-1:0] prev_w;
        if (g == 0) begin : g_first
            assign prev_w = '0;
        end else begin : g_rest
            assign prev_w = addr_q[g-1];
        end

        assign mode_w[g]            = mode_of(cfg_q[g]);
        assign cfg_flat[g*8 +: 8]   = cfg_q[g];
        assign rng_lo_o[g*PAW +: PAW] = lo_q[g];
        assign rng_hi_o[g*PAW +: PAW] = hi_q[g];

        pmp_entry_decode #(.XLEN(XLEN), .PAW(PAW), .CW(CW)) u_dec (
            .mode      (mode_w[g]),
            .addr      (addr_q[g]),
            .prev_addr (prev_w),
            .lo        (dec_lo[g]),
            .hi        (dec_hi[g])
        );

        logic [PAW-1:0] span;
        assign span = hi_q[g] - lo_q[g];

        a_r2_off_full: assert property (@(posedge clk) disable iff (rst)
            (!busy_q && mode_w[g] == MODE_OFF) |-> (lo_q[g] == '0 && hi_q[g] == '1));

        a_r4_na4_span: assert property (@(posedge clk) disable iff (rst)
            (!busy_q && mode_w[g] == MODE_NA4) |-> (span == PAW'(3) && lo_q[g][1:0] == 2'b00));

        a_r5_napot_aligned: assert property (@(posedge clk) disable iff (rst)
            (!busy_q && mode_w[g] == MODE_NAPOT)
                |-> (((span + PAW'(1)) & span) == '0 && (lo_q[g] & span) == '0));

        a_r8_bounds_hold: assert property (@(posedge clk) disable iff (rst)
            !busy_q |=> ($stable(lo_q[g]) && $stable(hi_q[g])));
    end

    pmp_rule_count #(.N(N), .CNTW(CNTW)) u_cnt (
        .cfg_flat (cfg_flat),
        .cnt      (cnt_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pend_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < N; i++) begin
                cfg_q[i]  <= '0;
                addr_q[i] <= '0;
                lo_q[i]   <= '0;
                hi_q[i]   <= '1;
            end
        end else begin
            busy_q <= wr_en;
            pend_q <= pend_d;
            for (int i = 0; i < N; i++) begin
                if (wr_en && idx_ok && int'(wr_idx) == i) begin
                    if (wr_sel) addr_q[i] <= wr_data;
                    else        cfg_q[i]  <= wr_data[7:0];
                end
                if (pend_q[i]) begin
                    lo_q[i] <= dec_lo[i];
                    hi_q[i] <= dec_hi[i];
                end
            end
            if (|pend_q) cnt_q <= cnt_d;
        end
    end

    assign busy_o       = busy_q;
    assign active_cnt_o = cnt_q;

    a_r8_busy_set: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> busy_q);

    a_r8_busy_clear: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !busy_q);

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= N);

    a_r7_count_match: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (cnt_q == cnt_d));

endmodule

// File: tb/sim_pmp_range_decoder.sv
module sim_pmp_range_decoder;
    localparam int N    = 4;
    localparam int XL   = 16;
    localparam int PAW  = XL + 2;
    localparam int IW   = 2;
    localparam int CNTW = 3;
    localparam logic [PAW-1:0] FULL = '1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 wr_en = 1'b0;
    logic [IW-1:0]        wr_idx = '0;
    logic                 wr_sel = 1'b0;
    logic [XL-1:0]        wr_data = '0;
    logic                 busy_o;
    logic [CNTW-1:0]      active_cnt_o;
    logic [N*PAW-1:0]     rng_lo_o;
    logic [N*PAW-1:0]     rng_hi_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pmp_range_decoder #(.NUM_ENTRIES(N), .XLEN(XL)) u0 (
        .clk, .rst, .wr_en, .wr_idx, .wr_sel, .wr_data,
        .busy_o, .active_cnt_o, .rng_lo_o, .rng_hi_o
    );

    // {idx, sel, data, exp_lo, exp_hi, exp_cnt}
    localparam int VW = IW + 1 + XL + PAW + PAW + CNTW;
    localparam int NV = 12;
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 1'b1, 16'h0100, 18'h00000, 18'h3FFFF, 3'd0},  // R2 off
        {2'd0, 1'b0, 16'h0008, 18'h00000, 18'h003FF, 3'd1},  // R3 tor entry 0
        {2'd1, 1'b1, 16'h0200, 18'h00000, 18'h3FFFF, 3'd1},  // R2 off
        {2'd1, 1'b0, 16'h0008, 18'h00400, 18'h007FF, 3'd2},  // R3 tor chained
        {2'd2, 1'b1, 16'h1234, 18'h00000, 18'h3FFFF, 3'd2},  // R2
        {2'd2, 1'b0, 16'h0010, 18'h048D0, 18'h048D3, 3'd3},  // R4 na4
        {2'd3, 1'b1, 16'h00FE, 18'h00000, 18'h3FFFF, 3'd3},  // R2
        {2'd3, 1'b0, 16'h0018, 18'h003F8, 18'h003FF, 3'd4},  // R5 t=0
        {2'd3, 1'b1, 16'h53FF, 18'h14000, 18'h15FFF, 3'd4},  // R5 t=10
        {2'd3, 1'b1, 16'hFFFF, 18'h00000, 18'h3FFFF, 3'd4},  // R6 all ones
        {2'd3, 1'b1, 16'h7FFF, 18'h00000, 18'h3FFFF, 3'd4},  // R5 t=15
        {2'd3, 1'b1, 16'hBFFF, 18'h20000, 18'h3FFFF, 3'd4}   // R5 t=14
    };

    function automatic logic [PAW-1:0] lo_of(int i);
        return rng_lo_o[i*PAW +: PAW];
    endfunction
    function automatic logic [PAW-1:0] hi_of(int i);
        return rng_hi_o[i*PAW +: PAW];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one write; returns at the negedge after the refresh edge.
    task automatic do_write(int idx, bit sel, logic [XL-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < N; i++) begin
            check("R1 lo", 32'(lo_of(i)), 32'd0);
            check("R1 hi", 32'(hi_of(i)), 32'(FULL));
        end
        check("R1 cnt", 32'(active_cnt_o), 32'd0);
        check("R1 busy", 32'(busy_o), 32'd0);

        // Table walk: R2..R7
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            int idx;
            e   = VEC[v];
            idx = int'(e[VW-1 -: IW]);
            do_write(idx, e[VW-IW-1], e[VW-IW-2 -: XL]);
            check("R2-mode lo", 32'(lo_of(idx)), 32'(e[CNTW+PAW +: PAW]));
            check("R2-mode hi", 32'(hi_of(idx)), 32'(e[CNTW +: PAW]));
            check("R7 cnt", 32'(active_cnt_o), 32'(e[CNTW-1:0]));
        end

        // R8 timing and R9 successor refresh
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'd0; wr_sel = 1'b1; wr_data = 16'h0300;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 busy high", 32'(busy_o), 32'd1);
        check("R8 old hi held", 32'(hi_of(0)), 32'h003FF);
        @(negedge clk);
        check("R8 busy low", 32'(busy_o), 32'd0);
        check("R8 new hi", 32'(hi_of(0)), 32'h00BFF);
        check("R9 succ lo", 32'(lo_of(1)), 32'h00C00);
        check("R9 succ hi", 32'(hi_of(1)), 32'h007FF);
        check("R10 e2 lo kept", 32'(lo_of(2)), 32'h048D0);
        check("R10 e3 lo kept", 32'(lo_of(3)), 32'h20000);
        @(negedge clk);
        check("R8 idle hold", 32'(hi_of(0)), 32'h00BFF);

        // R3 zero register wraps to all ones
        do_write(0, 1'b1, 16'h0000);
        check("R3 wrap lo", 32'(lo_of(0)), 32'd0);
        check("R3 wrap hi", 32'(hi_of(0)), 32'(FULL));
        check("R9 succ lo zero", 32'(lo_of(1)), 32'd0);

        // R7 disable an entry; R10 others untouched
        do_write(2, 1'b0, 16'h0000);
        check("R7 cnt drop", 32'(active_cnt_o), 32'd3);
        check("R2 off lo", 32'(lo_of(2)), 32'd0);
        check("R2 off hi", 32'(hi_of(2)), 32'(FULL));
        check("R10 e3 hi kept", 32'(hi_of(3)), 32'(FULL));
        check("R10 e1 hi kept", 32'(hi_of(1)), 32'h007FF);

        // R10 address write with off-mode successor leaves it full
        do_write(1, 1'b1, 16'h0040);
        check("R10 e2 still off", 32'(hi_of(2)), 32'(FULL));
        check("R3 e1 hi", 32'(hi_of(1)), 32'h000FF);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule